// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It learns from the past outcomes of each branch on its own. A table of shift registers, indexed by low bits of the branch address, keeps the most recent outcomes of every branch. That history value selects one 2-bit saturating counter, and the counter's upper bit gives the guess. A single parameter sets how the counters are organised. In shared mode, one counter table serves every branch. In per-address mode, every history register owns a private counter table.

A fetch stage drives the branch address on the predict port and reads the guess in the same cycle. When the branch resolves, the pipeline drives the branch address and the real outcome on the update port for one cycle. On that clock edge the block trains the selected counter using the history as it stood before the update. It then shifts the outcome into that branch's history. Any repeating pattern whose period fits in the history length settles into one counter per history value. Once the counters are warmed up, the guesses for such a pattern are always right.

Top module: `twolvl_bpred`

## Requirements
- R1: After reset every history register holds zero and every counter holds 1, so `pred_taken` is 0 for every address until the first update.
- R2: `pred_taken` is 1 exactly when the selected counter holds 2 or 3.
- R3: An update moves the selected counter up by one when the outcome is taken and down by one when it is not taken. The counter saturates at 3 and at 0.
- R4: An update first trains the counter addressed by the branch's old history. It then shifts the outcome into history bit 0 and drops the oldest bit (bit HIST_LEN-1).
- R5: The history register is selected by address bits `[PC_LSB +: log2(HIST_ENTRIES)]`. Addresses that agree in those bits share one history. Addresses that differ there do not affect each other's history.
- R6: With `SHARED_PT=1`, the counter index is the history value alone, so branches with equal histories train and read the same counter.
- R7: With `SHARED_PT=0`, the counter index is {history-register index, history value}, so each branch trains only its own table.
- R8: The prediction is combinational from the stored state. An update is visible from the cycle after it is presented. A predict at the same address in the same cycle sees the state before the update.
- R9: After warm-up, a branch that repeats always-taken, strict alternation, or taken-taken-not-not has no mispredictions.
- R10: When `upd_valid` is 0, no state changes, whatever `upd_pc` and `upd_taken` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_pc | input | PC_W | Address of the branch being fetched |
| pred_taken | output | 1 | Direction guess for `pred_pc` |
| upd_valid | input | 1 | Resolved branch present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Real outcome of the resolved branch |

## Verification
The bench builds the block twice from the same stimulus. The first copy uses the default shared mode with 512 history registers and 4-bit history. The second uses per-address mode with 16 history registers, which keeps its 256 counters small. With both copies running side by side, one sequence shows a counter trained by one branch being reused by another branch in shared mode and not in per-address mode. Aliasing shows up at two separate address strides: 2048 bytes for the shared copy and 64 bytes for the per-address copy. Every cycle is compared against a behavioural model. The pattern runs measure mispredictions after warm-up.

// File: rtl/twolvl_bpred_pkg.sv
package twolvl_bpred_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_FLOOR = 2'd0;
   localparam ctr_t CTR_CEIL  = 2'd3;
   localparam ctr_t CTR_INIT  = 2'd1;

   // saturating step toward the observed outcome
   function automatic ctr_t ctr_next(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_CEIL)  ? cur : cur + 2'd1;
      else       nxt = (cur == CTR_FLOOR) ? cur : cur - 2'd1;
      return nxt;
   endfunction

   function automatic logic ctr_says_taken(input ctr_t cur);
      return cur[1];
   endfunction

endpackage

// File: rtl/twolvl_bpred_hist.sv
module twolvl_bpred_hist #(
   parameter  int ENTRIES  = 512,
   parameter  int HIST_LEN = 4,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IDX_W-1:0]    rd_idx,
   output logic [HIST_LEN-1:0] rd_hist,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic                wr_taken,
   output logic [HIST_LEN-1:0] wr_hist
);

   logic [HIST_LEN-1:0] hist_q [ENTRIES];

   assign rd_hist = hist_q[rd_idx];
   assign wr_hist = hist_q[wr_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int e = 0; e < ENTRIES; e++) hist_q[e] <= '0;
      end else if (wr_en) begin
         // newest outcome enters bit 0, oldest falls off the top
         hist_q[wr_idx] <= HIST_LEN'({wr_hist, wr_taken});
      end
   end

endmodule

// File: rtl/twolvl_bpred_pattern.sv
module twolvl_bpred_pattern
   import twolvl_bpred_pkg::*;
#(
   parameter  int DEPTH  = 16,
   localparam int ADDR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] rd_addr,
   output ctr_t              rd_ctr,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_taken,
   output ctr_t              wr_old,
   output ctr_t              wr_new
);

   ctr_t ctr_q [DEPTH];

   assign rd_ctr = ctr_q[rd_addr];
   assign wr_old = ctr_q[wr_addr];
   assign wr_new = ctr_next(wr_old, wr_taken);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int d = 0; d < DEPTH; d++) ctr_q[d] <= CTR_INIT;
      end else if (wr_en) begin
         ctr_q[wr_addr] <= wr_new;
      end
   end

endmodule

// File: rtl/twolvl_bpred.sv
module twolvl_bpred
   import twolvl_bpred_pkg::*;
#(
   parameter  int PC_W         = 32,
   parameter  int PC_LSB       = 2,
   parameter  int HIST_ENTRIES = 512,
   parameter  int HIST_LEN     = 4,
   parameter  bit SHARED_PT    = 1'b1,
   localparam int IDX_W        = $clog2(HIST_ENTRIES),
   localparam int PT_TABLES    = SHARED_PT ? 1 : HIST_ENTRIES,
   localparam int PT_DEPTH     = PT_TABLES * (1 << HIST_LEN),
   localparam int PT_AW        = $clog2(PT_DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   output logic            pred_taken,
   input  logic            upd_valid,
   input  logic [PC_W-1:0] upd_pc,
   input  logic            upd_taken
);

   // ---------------- elaboration checks ----------------
   if (HIST_LEN < 1 || HIST_LEN > 16) begin : g_bad_hist_len
      $error("twolvl_bpred: HIST_LEN must lie in 1..16");
   end
   if (HIST_ENTRIES < 2 || (1 << IDX_W) != HIST_ENTRIES) begin : g_bad_entries
      $error("twolvl_bpred: HIST_ENTRIES must be a power of two, at least 2");
   end
   if (PC_LSB < 0 || PC_LSB + IDX_W > PC_W) begin : g_bad_pc_slice
      $error("twolvl_bpred: index slice does not fit inside PC_W");
   end

   // ---------------- history stage ----------------
   logic [IDX_W-1:0]    pred_idx, upd_idx;
   logic [HIST_LEN-1:0] pred_hist, upd_hist;

   assign pred_idx = pred_pc[PC_LSB +: IDX_W];
   assign upd_idx  = upd_pc[PC_LSB +: IDX_W];

   twolvl_bpred_hist #(
      .ENTRIES  (HIST_ENTRIES),
      .HIST_LEN (HIST_LEN)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (pred_idx),
      .rd_hist  (pred_hist),
      .wr_en    (upd_valid),
      .wr_idx   (upd_idx),
      .wr_taken (upd_taken),
      .wr_hist  (upd_hist)
   );

   // ---------------- counter addressing ----------------
   logic [PT_AW-1:0] pred_addr, upd_addr;
   logic             unused_pc_bits;

   assign unused_pc_bits = ^{pred_pc, upd_pc};

   if (SHARED_PT) begin : g_shared
      logic unused_idx;
      assign unused_idx = ^{pred_idx, upd_idx};
      assign pred_addr  = PT_AW'(pred_hist);
      assign upd_addr   = PT_AW'(upd_hist);
   end else begin : g_per_addr
      assign pred_addr = {pred_idx, pred_hist};
      assign upd_addr  = {upd_idx,  upd_hist};
   end

   // ---------------- pattern stage ----------------
   ctr_t pred_ctr, upd_ctr_old, upd_ctr_new;

   twolvl_bpred_pattern #(
      .DEPTH (PT_DEPTH)
   ) u_pattern (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_addr  (pred_addr),
      .rd_ctr   (pred_ctr),
      .wr_en    (upd_valid),
      .wr_addr  (upd_addr),
      .wr_taken (upd_taken),
      .wr_old   (upd_ctr_old),
      .wr_new   (upd_ctr_new)
   );

   assign pred_taken = ctr_says_taken(pred_ctr);

endmodule

// File: rtl/twolvl_bpred_chk.sv
module twolvl_bpred_chk #(
   parameter int PC_W     = 32,
   parameter int HIST_LEN = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [PC_W-1:0]     pred_pc,
   input logic                pred_taken,
   input logic                upd_valid,
   input logic [PC_W-1:0]     upd_pc,
   input logic                upd_taken,
   input logic [HIST_LEN-1:0] upd_hist,
   input logic [1:0]          ctr_old,
   input logic [1:0]          ctr_new
);

   logic                armed_q, prev_upd_q, prev_pred_q;
   logic [PC_W-1:0]     prev_upd_pc_q, prev_pred_pc_q;
   logic [HIST_LEN-1:0] exp_hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q        <= 1'b0;
         prev_upd_q     <= 1'b0;
         prev_pred_q    <= 1'b0;
         prev_upd_pc_q  <= '0;
         prev_pred_pc_q <= '0;
         exp_hist_q     <= '0;
      end else begin
         armed_q        <= 1'b1;
         prev_upd_q     <= upd_valid;
         prev_pred_q    <= pred_taken;
         prev_upd_pc_q  <= upd_pc;
         prev_pred_pc_q <= pred_pc;
         exp_hist_q     <= HIST_LEN'({upd_hist, upd_taken});
      end
   end

   AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |-> !pred_taken);  // R1

   AST_CTR_UP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && upd_taken |-> ctr_new >= ctr_old);  // R3

   AST_CTR_DN_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && !upd_taken |-> ctr_new <= ctr_old);  // R3

   AST_CTR_MID_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
      upd_valid && (ctr_old == 2'd1 || ctr_old == 2'd2) |-> ctr_new != ctr_old);  // R3

   AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && prev_upd_q && upd_pc == prev_upd_pc_q |-> upd_hist == exp_hist_q);  // R4

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q && !prev_upd_q && pred_pc == prev_pred_pc_q |-> pred_taken == prev_pred_q);  // R10

   AST_PRED_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(pred_taken));  // R2

endmodule

bind twolvl_bpred twolvl_bpred_chk #(
   .PC_W     (PC_W),
   .HIST_LEN (HIST_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pred_pc    (pred_pc),
   .pred_taken (pred_taken),
   .upd_valid  (upd_valid),
   .upd_pc     (upd_pc),
   .upd_taken  (upd_taken),
   .upd_hist   (upd_hist),
   .ctr_old    (upd_ctr_old),
   .ctr_new    (upd_ctr_new)
);

// File: tb/twolvl_bpred_tb.sv
module twolvl_bpred_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pred_pc = '0;
   logic        upd_valid = 1'b0;
   logic [31:0] upd_pc = '0;
   logic        upd_taken = 1'b0;
   logic        pt_s, pt_p;

   always #2 clk = ~clk;  // 250 MHz

   twolvl_bpred #(.HIST_ENTRIES(512), .HIST_LEN(4), .SHARED_PT(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_s),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

   twolvl_bpred #(.HIST_ENTRIES(16), .HIST_LEN(4), .SHARED_PT(1'b0)) u_dut_pa (
      .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_p),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

   // behavioural reference: plain integer arrays
   int hs [512];
   int cs [16];
   int hp [16];
   int cp [256];

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   int got_s, got_p;

   function automatic int ix_s(input logic [31:0] pc); return int'((pc >> 2) & 32'd511); endfunction
   function automatic int ix_p(input logic [31:0] pc); return int'((pc >> 2) & 32'd15);  endfunction

   function automatic int exp_s(input logic [31:0] pc);
      return (cs[hs[ix_s(pc)]] >= 2) ? 1 : 0;
   endfunction
   function automatic int exp_p(input logic [31:0] pc);
      return (cp[ix_p(pc) * 16 + hp[ix_p(pc)]] >= 2) ? 1 : 0;
   endfunction

   function automatic int bump(input int c, input bit t);
      if (t) return (c < 3) ? c + 1 : 3;
      return (c > 0) ? c - 1 : 0;
   endfunction

   task automatic model_update(input logic [31:0] pc, input bit t);
      int i, j;
      i = ix_s(pc);
      cs[hs[i]] = bump(cs[hs[i]], t);
      hs[i] = ((hs[i] << 1) | int'(t)) & 15;
      j = ix_p(pc);
      cp[j * 16 + hp[j]] = bump(cp[j * 16 + hp[j]], t);
      hp[j] = ((hp[j] << 1) | int'(t)) & 15;
   endtask

   task automatic check(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one clock: drive, compare both copies against the model, then train the model
   task automatic step(input logic [31:0] ppc, input bit uv, input logic [31:0] upc,
                       input bit ut, input string tag);
      @(negedge clk);
      pred_pc = ppc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
      #1;
      got_s = int'(pt_s);
      got_p = int'(pt_p);
      check({tag, " shared"}, got_s, exp_s(ppc));
      check({tag, " per-addr"}, got_p, exp_p(ppc));
      @(posedge clk);
      if (uv) model_update(upc, ut);
   endtask

   // repeat a 4-outcome pattern; count misses over the last 16 steps
   task automatic run_pattern(input logic [31:0] pc, input bit [3:0] pat, input string tag);
      int miss_s = 0, miss_p = 0;
      for (int r = 0; r < 12; r++) begin
         for (int b = 3; b >= 0; b--) begin
            step(pc, 1'b1, pc, pat[b], tag);
            if (r >= 8) begin
               if (got_s != int'(pat[b])) miss_s++;
               if (got_p != int'(pat[b])) miss_p++;
            end
         end
      end
      check({tag, " warm misses shared"}, miss_s, 0);
      check({tag, " warm misses per-addr"}, miss_p, 0);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) hs[i] = 0;
      for (int i = 0; i < 16;  i++) begin cs[i] = 1; hp[i] = 0; end
      for (int i = 0; i < 256; i++) cp[i] = 1;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: fresh state predicts not taken everywhere
      step(32'h0000_0000, 1'b0, 32'h0, 1'b0, "R1");
      check("R1 explicit shared", got_s, 0);
      step(32'h0000_0FFC, 1'b0, 32'h0, 1'b0, "R1");
      step(32'h1234_5678, 1'b0, 32'h0, 1'b0, "R1");
      check("R1 explicit per-addr", got_p, 0);

      // R9 (with R2, R4, R8 on every step): learned patterns
      run_pattern(32'h0000_0100, 4'b1111, "R9 always-taken");
      run_pattern(32'h0000_0204, 4'b1010, "R9 alternating");
      run_pattern(32'h0000_0308, 4'b1100, "R9 TTNN");

      // R6/R7: fresh branch reaching history 1111
      for (int k = 0; k < 4; k++) step(32'h0000_002C, 1'b1, 32'h0000_002C, 1'b1, "R6 R7 train");
      step(32'h0000_002C, 1'b0, 32'h0, 1'b0, "R6 R7 read");
      check("R6 shared table reused", got_s, 1);
      check("R7 private table fresh", got_p, 0);

      // R3: saturation up then down, R8: same-cycle read sees old state
      for (int k = 0; k < 7; k++) step(32'h0000_001C, 1'b1, 32'h0000_001C, 1'b1, "R3 up");
      for (int k = 0; k < 7; k++) step(32'h0000_001C, 1'b1, 32'h0000_001C, 1'b0, "R3 down");
      step(32'h0000_001C, 1'b1, 32'h0000_001C, 1'b1, "R8");

      // R10: no update, noise on update lines
      for (int k = 0; k < 6; k++)
         step(32'h0000_001C, 1'b0, 32'h0000_001C, k[0], "R10");

      // R5: aliasing strides 2048 (shared) and 64 (per-addr)
      step(32'h0000_081C, 1'b0, 32'h0, 1'b0, "R5 alias");
      step(32'h0000_005C, 1'b1, 32'h0000_005C, 1'b1, "R5 alias per-addr");
      step(32'h0000_001C, 1'b1, 32'h0000_081C, 1'b1, "R5 alias shared");
      step(32'h0000_0020, 1'b0, 32'h0, 1'b0, "R5 neighbour");

      // mixed stream over a small set of addresses, compared every clock
      for (int k = 0; k < 400; k++) begin
         logic [31:0] a, b;
         a = 32'h0000_0010 + 32'({$urandom_range(0, 7)} << 2) + ($urandom_range(0, 1) != 0 ? 32'h800 : 32'h0);
         b = 32'h0000_0010 + 32'({$urandom_range(0, 7)} << 2);
         step(a, $urandom_range(0, 3) != 0, b, $urandom_range(0, 2) != 0, "R2 R4 mixed");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule